// File: doc/BRIEF.md
# Data Address and Value Debug Watch

This block sits beside a processor's commit stage and watches every memory-access operation that completes. Each operation comes with a class code, an effective address, a data word and a string length, qualified by a valid strobe. The block compares the address against a set of programmable address registers. It can also compare the data against paired value registers. From these compares it raises per-comparator debug event pulses for an address read, an address write or a value match.

Whether an operation can count as a read, a write or neither depends on its class. Ordinary loads and stores are reads and writes. Cache-maintenance operations are sorted by whether they can change or expose memory contents. Operations that act on a whole congruence class rather than an address never qualify. String transfers of zero length touch no storage and are ignored.

A comparator switches to value mode when its byte-lane mask is non-zero. In value mode it reports a value event only when the address and the selected data lanes both match, and its plain address events are suppressed. Software programs the comparators through a single write port.

Top module: `addr_value_watch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every event output is low.
- R2: Class code 0 (load) counts as a read and class code 1 (store) counts as a write.
- R3: Class codes 2 (data-cache block invalidate) and 3 (data-cache block zero) count as writes only.
- R4: Class codes 4 (data-cache congruence-class invalidate), 5 (data-cache line read), 12 (instruction-cache congruence-class invalidate) and 13 (instruction-cache line read) never raise any event.
- R5: Class codes 6 and 7 (data-cache touch, touch for store), 10 (instruction-cache block invalidate) and 11 (instruction-cache touch) count as reads only.
- R6: Class codes 8 (data-cache block flush) and 9 (data-cache block store) count as writes only and never raise a read event.
- R7: Class code 14 (string load) counts as a read and 15 (string store) as a write, but only when the string length is non-zero; with length zero they raise no event.
- R8: In address mode, comparator k raises a read event when a read-class operation's address equals its address register in every bit and its read enable is set, and a write event under the same conditions for write-class operations with its write enable set.
- R9: A value event for comparator k requires that the address matches, that the matching read or write enable is set, and that every data byte lane selected in its mask equals the same lane of its value register; lanes outside the mask always count as matching.
- R10: When comparator k's byte-lane mask is non-zero it is in value mode, and it never raises its read or write address events.
- R11: Events are registered. An operation accepted on one clock edge shows its events for exactly the following cycle, and a cycle without a valid operation leaves all events low on the next cycle.
- R12: Configuration writes select a register by index: index k (k below NCMP) is comparator k's address, NCMP+k is its value, and 2*NCMP is the control word. In the control word, comparator k owns the 2+NB bits starting at k*(2+NB): bit 0 is the read enable, bit 1 the write enable, and the next NB bits are the byte-lane mask with bit i selecting data bits [8i+7:8i]. A write takes effect for operations presented from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Configuration register index |
| cfg_wdata | input | DW | Configuration write data |
| op_valid | input | 1 | A committed operation is presented this cycle |
| op_class | input | 4 | Operation class code |
| op_addr | input | AW | Effective address of the operation |
| op_data | input | DW | Data value of the operation |
| op_strlen | input | LW | String length, used only by string classes |
| ev_rd | output | NCMP | Address-read event per comparator |
| ev_wr | output | NCMP | Address-write event per comparator |
| ev_val | output | NCMP | Value-match event per comparator |

## Verification
The assertions assume that the operation fields are known whenever the valid strobe is high. They also assume that each operation's events come from the configuration in force when it was accepted. That holds only if configuration writes do not land in the same cycle as an operation they are meant to affect. The bench keeps to this by issuing configuration writes only while no operation is valid. It drives every input on the falling edge and sweeps all sixteen classes against every enable and mask combination, with address hits, single-bit misses and data that differs in masked and unmasked lanes.

// File: rtl/avw_pkg.sv
// Package: shared operation class codes and access-kind type for the
// address/value debug watch. Assumes a 4-bit class code from the pipeline.
package avw_pkg;

    typedef enum logic [3:0] {
        OP_LOAD         = 4'd0,
        OP_STORE        = 4'd1,
        OP_DC_INV_BLK   = 4'd2,
        OP_DC_ZERO_BLK  = 4'd3,
        OP_DC_CC_INV    = 4'd4,
        OP_DC_READ      = 4'd5,
        OP_DC_TOUCH     = 4'd6,
        OP_DC_TOUCH_ST  = 4'd7,
        OP_DC_FLUSH     = 4'd8,
        OP_DC_STORE_BLK = 4'd9,
        OP_IC_INV_BLK   = 4'd10,
        OP_IC_TOUCH     = 4'd11,
        OP_IC_CC_INV    = 4'd12,
        OP_IC_READ      = 4'd13,
        OP_STR_LOAD     = 4'd14,
        OP_STR_STORE    = 4'd15
    } op_class_e;

    typedef struct packed {
        logic is_wr;
        logic is_rd;
    } access_t;

endpackage

// File: rtl/avw_cfg_regs.sv
// Module: configuration register file for the comparators.
// Holds one address and one value register per comparator, plus a packed
// control word with read/write enables and byte-lane masks.
// Assumes AW <= DW and NCMP*(2+NB) <= DW.
module avw_cfg_regs #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NCMP = 2,
    parameter int NB   = DW / 8,
    parameter int SELW = $clog2(2 * NCMP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SELW-1:0]            cfg_sel,
    input  logic [DW-1:0]              cfg_wdata,
    output logic [NCMP-1:0][AW-1:0]    ref_addr,
    output logic [NCMP-1:0][DW-1:0]    ref_val,
    output logic [NCMP-1:0]            rd_en,
    output logic [NCMP-1:0]            wr_en,
    output logic [NCMP-1:0][NB-1:0]    lane_mask
);
    localparam int CW       = 2 + NB;
    localparam int CTRL_IDX = 2 * NCMP;

    logic [NCMP*CW-1:0] ctrl_q;

    // Control word: enables and masks for all comparators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we && (int'(cfg_sel) == CTRL_IDX)) begin
            ctrl_q <= cfg_wdata[NCMP*CW-1:0];
        end
    end

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp_regs
        // Address register of comparator k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_addr[k] <= '0;
            end else if (cfg_we && (int'(cfg_sel) == k)) begin
                ref_addr[k] <= cfg_wdata[AW-1:0];
            end
        end

        // Value register of comparator k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_val[k] <= '0;
            end else if (cfg_we && (int'(cfg_sel) == NCMP + k)) begin
                ref_val[k] <= cfg_wdata;
            end
        end

        assign rd_en[k]     = ctrl_q[k*CW];
        assign wr_en[k]     = ctrl_q[k*CW+1];
        assign lane_mask[k] = ctrl_q[k*CW+2 +: NB];
    end

endmodule

// File: rtl/avw_op_classify.sv
// Module: decides whether an operation class counts as a read, a write or
// neither for address compares. Purely combinational.
// Assumes op_strlen is meaningful only for the two string classes.
module avw_op_classify #(
    parameter int LW = 7
) (
    input  logic [3:0]       op_class,
    input  logic [LW-1:0]    op_strlen,
    output avw_pkg::access_t acc
);
    import avw_pkg::*;

    logic len_nz;
    assign len_nz = |op_strlen;

    // Map each class code to its access kind.
    always_comb begin
        acc = '0;
        unique case (op_class_e'(op_class))
            OP_LOAD, OP_DC_TOUCH, OP_DC_TOUCH_ST,
            OP_IC_INV_BLK, OP_IC_TOUCH:            acc.is_rd = 1'b1;
            OP_STORE, OP_DC_INV_BLK, OP_DC_ZERO_BLK,
            OP_DC_FLUSH, OP_DC_STORE_BLK:          acc.is_wr = 1'b1;
            OP_STR_LOAD:                           acc.is_rd = len_nz;
            OP_STR_STORE:                          acc.is_wr = len_nz;
            OP_DC_CC_INV, OP_DC_READ,
            OP_IC_CC_INV, OP_IC_READ:              acc = '0;
            default:                               acc = '0;
        endcase
    end

endmodule

// File: rtl/avw_comparator.sv
// Module: one address/value comparator. Compares the operation address
// against its address register and, in value mode (non-zero lane mask),
// the selected data lanes against its value register. Outputs are
// registered single-cycle pulses.
// Assumes acc is already zero for operations that cannot qualify.
module avw_comparator #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  avw_pkg::access_t acc,
    input  logic [AW-1:0]    op_addr,
    input  logic [DW-1:0]    op_data,
    input  logic [AW-1:0]    ref_addr,
    input  logic [DW-1:0]    ref_val,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [NB-1:0]    lane_mask,
    output logic             ev_rd,
    output logic             ev_wr,
    output logic             ev_val
);
    logic          addr_hit;
    logic          rd_qual;
    logic          wr_qual;
    logic          val_mode;
    logic [NB-1:0] lane_ok;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        // A lane matches when unselected or equal to the reference byte.
        assign lane_ok[i] = !lane_mask[i] || (op_data[8*i +: 8] == ref_val[8*i +: 8]);
    end

    // Qualify the operation against address and enables.
    always_comb begin
        addr_hit = (op_addr == ref_addr);
        rd_qual  = op_valid && acc.is_rd && rd_en && addr_hit;
        wr_qual  = op_valid && acc.is_wr && wr_en && addr_hit;
        val_mode = |lane_mask;
    end

    // Register the event pulses; value mode replaces address events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rd  <= 1'b0;
            ev_wr  <= 1'b0;
            ev_val <= 1'b0;
        end else begin
            ev_rd  <= rd_qual && !val_mode;
            ev_wr  <= wr_qual && !val_mode;
            ev_val <= (rd_qual || wr_qual) && val_mode && (&lane_ok);
        end
    end

endmodule

// File: rtl/addr_value_watch.sv
// Module: top of the data address/value debug watch. Classifies each
// committed operation, then feeds NCMP comparators configured through a
// single write port.
// Assumes operation fields are known whenever op_valid is high.
module addr_value_watch #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int LW   = 7,
    parameter int NCMP = 2,
    parameter int NB   = DW / 8,
    parameter int SELW = $clog2(2 * NCMP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SELW-1:0]  cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             op_valid,
    input  logic [3:0]       op_class,
    input  logic [AW-1:0]    op_addr,
    input  logic [DW-1:0]    op_data,
    input  logic [LW-1:0]    op_strlen,
    output logic [NCMP-1:0]  ev_rd,
    output logic [NCMP-1:0]  ev_wr,
    output logic [NCMP-1:0]  ev_val
);
    logic [NCMP-1:0][AW-1:0] ref_addr;
    logic [NCMP-1:0][DW-1:0] ref_val;
    logic [NCMP-1:0]         rd_en;
    logic [NCMP-1:0]         wr_en;
    logic [NCMP-1:0][NB-1:0] lane_mask;
    avw_pkg::access_t        acc;

    avw_cfg_regs #(
        .AW(AW), .DW(DW), .NCMP(NCMP), .NB(NB), .SELW(SELW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ref_addr  (ref_addr),
        .ref_val   (ref_val),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .lane_mask (lane_mask)
    );

    avw_op_classify #(.LW(LW)) u_cls (
        .op_class  (op_class),
        .op_strlen (op_strlen),
        .acc       (acc)
    );

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        avw_comparator #(.AW(AW), .DW(DW), .NB(NB)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_valid  (op_valid),
            .acc       (acc),
            .op_addr   (op_addr),
            .op_data   (op_data),
            .ref_addr  (ref_addr[k]),
            .ref_val   (ref_val[k]),
            .rd_en     (rd_en[k]),
            .wr_en     (wr_en[k]),
            .lane_mask (lane_mask[k]),
            .ev_rd     (ev_rd[k]),
            .ev_wr     (ev_wr[k]),
            .ev_val    (ev_val[k])
        );
    end

endmodule

// File: rtl/avw_chk.sv
// Module: assertion checker for addr_value_watch, attached by bind.
// Relates operation classes at the inputs to event pulses one cycle later.
// Assumes op fields are known while op_valid is high.
module avw_chk #(
    parameter int LW   = 7,
    parameter int NCMP = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [3:0]      op_class,
    input logic [LW-1:0]   op_strlen,
    input logic [NCMP-1:0] ev_rd,
    input logic [NCMP-1:0] ev_wr,
    input logic [NCMP-1:0] ev_val
);
    import avw_pkg::*;

    logic cls_none;
    logic cls_rd_only;
    logic cls_wr_never_rd;
    logic str_empty;

    // Decode the class groups the properties refer to.
    always_comb begin
        cls_none        = (op_class == OP_DC_CC_INV) || (op_class == OP_DC_READ) ||
                          (op_class == OP_IC_CC_INV) || (op_class == OP_IC_READ);
        cls_rd_only     = (op_class == OP_DC_TOUCH) || (op_class == OP_DC_TOUCH_ST) ||
                          (op_class == OP_IC_INV_BLK) || (op_class == OP_IC_TOUCH);
        cls_wr_never_rd = (op_class == OP_DC_FLUSH) || (op_class == OP_DC_STORE_BLK);
        str_empty       = ((op_class == OP_STR_LOAD) || (op_class == OP_STR_STORE)) &&
                          (op_strlen == '0);
    end

    // R4
    no_event_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls_none) |=> ((ev_rd | ev_wr | ev_val) == '0));

    // R5
    touch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls_rd_only) |=> (ev_wr == '0));

    // R6
    flush_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls_wr_never_rd) |=> (ev_rd == '0));

    // R7
    empty_string_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && str_empty) |=> ((ev_rd | ev_wr | ev_val) == '0));

    // R10
    value_supersedes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_val & (ev_rd | ev_wr)) == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ((ev_rd | ev_wr | ev_val) == '0));

    // R8
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_rd & ev_wr) == '0));

endmodule

bind addr_value_watch avw_chk #(.LW(LW), .NCMP(NCMP)) u_avw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_class  (op_class),
    .op_strlen (op_strlen),
    .ev_rd     (ev_rd),
    .ev_wr     (ev_wr),
    .ev_val    (ev_val)
);

// File: tb/tb_addr_value_watch.sv
// Bench: sweeps every class code against every enable/mask setting, with
// address hits and misses, data lane variations and string lengths.
module tb_addr_value_watch;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int LW   = 7;
    localparam int NCMP = 2;
    localparam int NB   = DW / 8;
    localparam int SELW = $clog2(2 * NCMP + 1);
    localparam int CW   = 2 + NB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [SELW-1:0] cfg_sel = '0;
    logic [DW-1:0]   cfg_wdata = '0;
    logic            op_valid = 1'b0;
    logic [3:0]      op_class = '0;
    logic [AW-1:0]   op_addr = '0;
    logic [DW-1:0]   op_data = '0;
    logic [LW-1:0]   op_strlen = '0;
    logic [NCMP-1:0] ev_rd;
    logic [NCMP-1:0] ev_wr;
    logic [NCMP-1:0] ev_val;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW-1:0] ref_a [NCMP];
    logic [DW-1:0] ref_v [NCMP];
    logic          cf_rd [NCMP];
    logic          cf_wr [NCMP];
    logic [NB-1:0] cf_m  [NCMP];

    addr_value_watch #(.AW(AW), .DW(DW), .LW(LW), .NCMP(NCMP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .op_valid(op_valid), .op_class(op_class),
        .op_addr(op_addr), .op_data(op_data), .op_strlen(op_strlen),
        .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_val(ev_val)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [3*NCMP-1:0] act,
                         input logic [3*NCMP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual val/wr/rd=%b expected=%b", req, act, exp);
        end
    endtask

    // Access kind per class code, bit1 = write, bit0 = read (R2..R7).
    function automatic logic [1:0] exp_kind(input int cls, input int len);
        case (cls)
            0:               return 2'b01;          // R2 load
            1:               return 2'b10;          // R2 store
            2, 3:            return 2'b10;          // R3
            4, 5, 12, 13:    return 2'b00;          // R4
            6, 7, 10, 11:    return 2'b01;          // R5
            8, 9:            return 2'b10;          // R6
            14:              return (len != 0) ? 2'b01 : 2'b00;  // R7
            15:              return (len != 0) ? 2'b10 : 2'b00;  // R7
            default:         return 2'b00;
        endcase
    endfunction

    // Expected {val, wr, rd} for comparator k (R8, R9, R10).
    function automatic logic [2:0] exp_cmp(input int k, input logic [1:0] kind,
                                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic hit, er, ew, dm;
        hit = (a == ref_a[k]);
        er  = hit && kind[0] && cf_rd[k];
        ew  = hit && kind[1] && cf_wr[k];
        dm  = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (cf_m[k][i] && (d[8*i +: 8] != ref_v[k][8*i +: 8])) dm = 1'b0;
        end
        if (cf_m[k] != '0) return {(er || ew) && dm, 1'b0, 1'b0};
        return {1'b0, ew, er};
    endfunction

    task automatic cfg_write(input int sel, input logic [DW-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = SELW'(sel);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // R12: program comparator controls via the packed control word.
    task automatic program_ctrl(input int s0, input int s1);
        logic [DW-1:0] w;
        logic [NB-1:0] masks [4];
        int sel [NCMP];
        masks[0] = 4'b0000; masks[1] = 4'b0001; masks[2] = 4'b1111; masks[3] = 4'b0110;
        sel[0] = s0; sel[1] = s1;
        w = '0;
        for (int k = 0; k < NCMP; k++) begin
            cf_rd[k] = sel[k][0];
            cf_wr[k] = sel[k][1];
            cf_m[k]  = masks[(sel[k] >> 2) & 3];
            w[k*CW]       = cf_rd[k];
            w[k*CW+1]     = cf_wr[k];
            w[k*CW+2 +: NB] = cf_m[k];
        end
        cfg_write(2 * NCMP, w);
    endtask

    task automatic run_op(input int cls, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int len, input string req);
        logic [3*NCMP-1:0] exp;
        logic [1:0] kind;
        logic [2:0] e;
        kind = exp_kind(cls, len);
        for (int k = 0; k < NCMP; k++) begin
            e = exp_cmp(k, kind, a, d);
            exp[k]          = e[0];
            exp[NCMP+k]     = e[1];
            exp[2*NCMP+k]   = e[2];
        end
        @(negedge clk);
        op_valid  = 1'b1;
        op_class  = 4'(cls);
        op_addr   = a;
        op_data   = d;
        op_strlen = LW'(len);
        @(negedge clk);
        op_valid  = 1'b0;
        check(req, {ev_val, ev_wr, ev_rd}, exp);
        @(negedge clk);
        check("R11 pulse ends", {ev_val, ev_wr, ev_rd}, '0);
    endtask

    initial begin
        logic [DW-1:0] dv;
        logic [AW-1:0] av;
        int vb;
        ref_a[0] = 32'h1000_0040; ref_a[1] = 32'h2000_0084;
        ref_v[0] = 32'hA1B2_C3D4; ref_v[1] = 32'h5E6F_7081;
        for (int k = 0; k < NCMP; k++) begin
            cf_rd[k] = 1'b0; cf_wr[k] = 1'b0; cf_m[k] = '0;
        end

        repeat (3) @(negedge clk);
        check("R1 in reset", {ev_val, ev_wr, ev_rd}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {ev_val, ev_wr, ev_rd}, '0);

        // R12: address and value registers at their indices.
        for (int k = 0; k < NCMP; k++) begin
            cfg_write(k, ref_a[k]);
            cfg_write(NCMP + k, ref_v[k]);
        end

        for (int cs = 0; cs < 16; cs++) begin
            program_ctrl(cs, (cs + 5) % 16);
            for (int cls = 0; cls < 16; cls++) begin
                for (int as = 0; as < 3; as++) begin
                    // R8: selector 2 misses comparator 0 by one address bit.
                    av = (as == 2) ? (ref_a[0] ^ 32'h1) : ref_a[as];
                    vb = (as == 1) ? 1 : 0;
                    for (int ds = 0; ds < 4; ds++) begin
                        // R9: exact, upper lane differs, lane 0 differs, all differ.
                        case (ds)
                            0:       dv = ref_v[vb];
                            1:       dv = ref_v[vb] ^ 32'hFF00_0000;
                            2:       dv = ref_v[vb] ^ 32'h0000_00FF;
                            default: dv = ~ref_v[vb];
                        endcase
                        for (int ln = 0; ln < 2; ln++) begin
                            run_op(cls, av, dv, ln * 9, "R2-R10 sweep");
                        end
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule